// File: doc/BRIEF.md
# I2C Slave Address Recognizer with Don't-Care Masking

This block is the address stage of an I2C slave. A bus front end turns the sampled SCL and SDA lines into single-cycle event strobes: start condition, stop condition, SCL rising edge (with the SDA level sampled on it) and SCL falling edge. The block counts the bits, assembles the address byte and compares it with a programmed own address. The comparison ignores every address bit whose mask bit is set. If the address matches, the block pulls SDA low for the acknowledge clock. On a full address match it also copies the received byte into a capture register and raises a one-cycle interrupt. Software reads the captured byte to learn which of the masked aliases was addressed.

Two static inputs set the mode. The first chooses between 7-bit and 10-bit addressing. The second chooses between two masking schemes. The narrow scheme can only mask address bits 5..1, so the top bits are always compared. The wide scheme can mask bits 7..1. When the scheme input is low, the wide scheme is used, and this is the intended default after reset. A 10-bit address arrives in two bytes. The first byte is a fixed header that carries the two high address bits and is never masked. The second byte carries the low eight address bits and is compared under the mask.

The front end must deliver its event strobes at least two clock cycles apart.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is asserted and right after it, `ack_drive` and `addr_irq` are 0 and `addr_buf` is 8'h00.
- R2: With 7-bit addressing and `cfg_mask5`=0, address byte bits 7..1 are compared with `own_lo[7:1]`. Each bit is skipped when `addr_mask[i-1]` is set (that mask bit covers address bit i). Byte bit 0, the read/write bit, is never compared.
- R3: With 7-bit addressing and `cfg_mask5`=1, only `addr_mask[4:0]` (address bits 5..1) can mask. `addr_mask[6:5]` have no effect, and address bits 7 and 6 must always equal the own address.
- R4: With 10-bit addressing, the first byte is acknowledged only if it equals {5'b11110, `own_hi`, 1'b0}. The mask never applies to it. Acknowledging this byte neither raises the interrupt nor changes `addr_buf`.
- R5: With 10-bit addressing, the second byte is compared with `own_lo`. In the narrow scheme (`cfg_mask5`=1), `addr_mask[4:1]` mask bits 5..2 and `addr_mask[0]` masks bits 1 and 0 together, while bits 7..6 are always compared. In the wide scheme, `addr_mask[6:0]` mask bits 7..1 and `addr_mask[0]` also masks bit 0.
- R6: `ack_drive` goes high on the SCL falling edge that follows the eighth rising edge of a matching byte. It stays high through the ninth rising edge and goes low on the falling edge after that.
- R7: Each full address match (the 7-bit byte, or the 10-bit second byte) loads the received byte into `addr_buf` and gives exactly one `addr_irq` pulse, one cycle wide.
- R8: A byte that does not match gets no acknowledge, leaves `addr_buf` and `addr_irq` unchanged, and causes every later byte to be ignored until the next start.
- R9: A start condition in the middle of a byte discards that byte and begins a new address phase. A stop condition returns the block to idle, where bytes are ignored until a start.
- R10: After a full match, later bytes in the same transfer are not acknowledged and raise no interrupt.
- R11: With own address byte A0h, 7-bit addressing, the narrow scheme and mask 5'b00111, exactly the eight bytes A0h, A2h, …, AEh are acknowledged. With 10-bit addressing, the same own low byte and mask acknowledge exactly the sixteen second bytes A0h..AFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ten_bit | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cfg_mask5 | input | 1 | 1 = narrow mask (bits 5..1), 0 = wide mask (bits 7..1) |
| own_hi | input | 2 | Own address bits 9..8 (10-bit mode) |
| own_lo | input | 8 | Own address byte: bits 7..1 in 7-bit mode, low byte in 10-bit mode |
| addr_mask | input | 7 | Bit i set = address bit i+1 is don't-care |
| ev_start | input | 1 | Start or repeated start strobe |
| ev_stop | input | 1 | Stop strobe |
| scl_rise | input | 1 | SCL rising-edge strobe, `sda_in` is valid with it |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Sampled SDA level |
| ack_drive | output | 1 | 1 = pull SDA low (acknowledge) |
| addr_buf | output | 8 | Last fully matched address byte |
| addr_irq | output | 1 | One-cycle pulse on a full address match |

## Verification
A fault in the bit counter or the shift register would show up as a wrong acknowledge on the very next address byte, or as an acknowledge placed on the wrong SCL pulse. A fault in the mask expansion would wrongly accept or reject particular aliases, and the bench catches this by sweeping every address value under several masks and both schemes. A fault in the control state would show up within one transfer: an acknowledged data byte, an acknowledge after a miss, a second interrupt, or a capture register that changed without an interrupt.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int MASK_W   = 7;
    localparam int HI_W     = 2;
    localparam int PREFIX_W = BYTE_W - HI_W - 1;

    localparam logic [PREFIX_W-1:0] HDR10_PREFIX = 5'b11110;
    localparam logic [CNT_W-1:0]    CNT_LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]    CNT_ACK_WAIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]    CNT_ACK_CLK  = CNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HDR_OK,
        ST_MATCHED,
        ST_SKIP
    } am_state_t;

    typedef struct packed {
        logic ten_bit;
        logic mask5;
    } am_cfg_t;

    typedef struct packed {
        logic hit;
        logic final_hit;
    } am_verdict_t;

    // Per-bit don't-care vector over a received address byte.
    function automatic logic [BYTE_W-1:0] expand_mask(
        input logic [MASK_W-1:0] m,
        input am_cfg_t           cfg
    );
        logic [BYTE_W-1:0] r;
        r = {m, 1'b0};
        if (cfg.mask5) r[BYTE_W-1:BYTE_W-2] = 2'b00;
        if (cfg.ten_bit) r[0] = m[0];
        else             r[0] = 1'b1;
        return r;
    endfunction

    function automatic logic masked_eq(
        input logic [BYTE_W-1:0] a,
        input logic [BYTE_W-1:0] b,
        input logic [BYTE_W-1:0] dc
    );
        return ((a ^ b) & ~dc) == '0;
    endfunction

endpackage

// File: rtl/i2cam_shifter.sv
module i2cam_shifter
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_done,
    output logic              ack_open,
    output logic              ack_close,
    output logic              in_ack_slot
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
        end else if (ev_start || ev_stop) begin
            cnt       <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (scl_rise) begin
                if (cnt < CNT_ACK_WAIT) begin
                    byte_q    <= {byte_q[BYTE_W-2:0], sda_in};
                    cnt       <= cnt + 1'b1;
                    byte_done <= (cnt == CNT_LAST_BIT);
                end else if (cnt == CNT_ACK_WAIT) begin
                    cnt <= CNT_ACK_CLK;
                end
            end else if (scl_fall && cnt == CNT_ACK_CLK) begin
                cnt <= '0;
            end
        end
    end

    assign ack_open    = scl_fall && (cnt == CNT_ACK_WAIT) && !ev_start && !ev_stop;
    assign ack_close   = scl_fall && (cnt == CNT_ACK_CLK);
    assign in_ack_slot = (cnt >= CNT_ACK_WAIT);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_ACK_CLK);

    // R9
    restart_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |=> (cnt == '0));

endmodule

// File: rtl/i2cam_compare.sv
module i2cam_compare
    import i2cam_pkg::*;
(
    input  am_cfg_t           cfg,
    input  logic [HI_W-1:0]   own_hi,
    input  logic [BYTE_W-1:0] own_lo,
    input  logic [MASK_W-1:0] addr_mask,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              expect_low,
    output am_verdict_t       verdict
);

    logic [BYTE_W-1:0] dc;
    logic              hdr_ok;
    logic              low_ok;

    always_comb begin
        dc     = expand_mask(addr_mask, cfg);
        low_ok = masked_eq(rx_byte, own_lo, dc);
        hdr_ok = (rx_byte[BYTE_W-1:HI_W+1] == HDR10_PREFIX)
              && (rx_byte[HI_W:1] == own_hi)
              && !rx_byte[0];
        if (!cfg.ten_bit) begin
            verdict.hit       = low_ok;
            verdict.final_hit = 1'b1;
        end else if (expect_low) begin
            verdict.hit       = low_ok;
            verdict.final_hit = 1'b1;
        end else begin
            verdict.hit       = hdr_ok;
            verdict.final_hit = 1'b0;
        end
    end

endmodule

// File: rtl/i2cam_ctrl.sv
module i2cam_ctrl
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_q,
    input  am_verdict_t       verdict,
    input  logic              ack_open,
    input  logic              ack_close,
    output am_state_t         state,
    output logic              ack_drive,
    output logic [BYTE_W-1:0] addr_buf,
    output logic              addr_irq
);

    logic ack_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ack_pend  <= 1'b0;
            ack_drive <= 1'b0;
            addr_buf  <= '0;
            addr_irq  <= 1'b0;
        end else begin
            addr_irq <= 1'b0;
            if (ev_start) begin
                state     <= ST_ADDR;
                ack_pend  <= 1'b0;
                ack_drive <= 1'b0;
            end else if (ev_stop) begin
                state     <= ST_IDLE;
                ack_pend  <= 1'b0;
                ack_drive <= 1'b0;
            end else begin
                if (byte_done && (state == ST_ADDR || state == ST_HDR_OK)) begin
                    if (verdict.hit) begin
                        ack_pend <= 1'b1;
                        if (verdict.final_hit) begin
                            state    <= ST_MATCHED;
                            addr_buf <= byte_q;
                            addr_irq <= 1'b1;
                        end else begin
                            state <= ST_HDR_OK;
                        end
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                if (ack_open && ack_pend) ack_drive <= 1'b1;
                if (ack_close) begin
                    ack_drive <= 1'b0;
                    ack_pend  <= 1'b0;
                end
            end
        end
    end

    // R7
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        addr_irq |=> !addr_irq);

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_irq |-> $stable(addr_buf));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |=> !ack_drive);

    // R10
    matched_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MATCHED && byte_done && !ev_start && !ev_stop) |=> !addr_irq);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ten_bit,
    input  logic              cfg_mask5,
    input  logic [HI_W-1:0]   own_hi,
    input  logic [BYTE_W-1:0] own_lo,
    input  logic [MASK_W-1:0] addr_mask,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              ack_drive,
    output logic [BYTE_W-1:0] addr_buf,
    output logic              addr_irq
);

    am_cfg_t           cfg;
    am_verdict_t       verdict;
    am_state_t         state;
    logic [BYTE_W-1:0] byte_q;
    logic              byte_done;
    logic              ack_open;
    logic              ack_close;
    logic              in_ack_slot;

    assign cfg.ten_bit = cfg_ten_bit;
    assign cfg.mask5   = cfg_mask5;

    i2cam_shifter u_shifter (
        .clk        (clk),
        .rst        (rst),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_in     (sda_in),
        .byte_q     (byte_q),
        .byte_done  (byte_done),
        .ack_open   (ack_open),
        .ack_close  (ack_close),
        .in_ack_slot(in_ack_slot)
    );

    i2cam_compare u_compare (
        .cfg       (cfg),
        .own_hi    (own_hi),
        .own_lo    (own_lo),
        .addr_mask (addr_mask),
        .rx_byte   (byte_q),
        .expect_low(state == ST_HDR_OK),
        .verdict   (verdict)
    );

    i2cam_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .byte_done(byte_done),
        .byte_q   (byte_q),
        .verdict  (verdict),
        .ack_open (ack_open),
        .ack_close(ack_close),
        .state    (state),
        .ack_drive(ack_drive),
        .addr_buf (addr_buf),
        .addr_irq (addr_irq)
    );

    // R6
    ack_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ack_drive |-> in_ack_slot);

    // R6
    ack_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drive) |-> $past(scl_fall));

    // R3
    top_bits_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && verdict.hit && verdict.final_hit && cfg_mask5)
            |-> (byte_q[BYTE_W-1:BYTE_W-2] == own_lo[BYTE_W-1:BYTE_W-2]));

    // R8
    miss_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && !verdict.hit) |=> !addr_irq);

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ten_bit = 1'b0;
    logic       cfg_mask5 = 1'b0;
    logic [1:0] own_hi = 2'b00;
    logic [7:0] own_lo = 8'h00;
    logic [6:0] addr_mask = 7'h00;
    logic       ev_start = 1'b0;
    logic       ev_stop = 1'b0;
    logic       scl_rise = 1'b0;
    logic       scl_fall = 1'b0;
    logic       sda_in = 1'b1;
    logic       ack_drive;
    logic [7:0] addr_buf;
    logic       addr_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_addr_match u_dut (
        .clk(clk), .rst(rst), .cfg_ten_bit(cfg_ten_bit), .cfg_mask5(cfg_mask5),
        .own_hi(own_hi), .own_lo(own_lo), .addr_mask(addr_mask),
        .ev_start(ev_start), .ev_stop(ev_stop), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .sda_in(sda_in), .ack_drive(ack_drive),
        .addr_buf(addr_buf), .addr_irq(addr_irq)
    );

    always @(posedge clk) if (!rst && addr_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp7(input logic [7:0] b, input logic [7:0] own,
                                input logic [6:0] m, input bit m5);
        logic [6:0] dc;
        dc = m5 ? {2'b00, m[4:0]} : m;
        return ((b[7:1] ^ own[7:1]) & ~dc) == 7'd0;
    endfunction

    function automatic bit exp10(input logic [7:0] b, input logic [7:0] own,
                                 input logic [6:0] m, input bit m5);
        logic [7:0] dc;
        dc = m5 ? {2'b00, m[4:1], m[0], m[0]} : {m, m[0]};
        return ((b ^ own) & ~dc) == 8'd0;
    endfunction

    task automatic do_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic clk_bit(input logic v);
        @(negedge clk) begin sda_in = v; scl_rise = 1'b1; end
        @(negedge clk) scl_rise = 1'b0;
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a1,
                             output logic a2, output logic a3);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        a1 = ack_drive;
        @(negedge clk) begin sda_in = 1'b1; scl_rise = 1'b1; end
        @(negedge clk) scl_rise = 1'b0;
        a2 = ack_drive;
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        a3 = ack_drive;
    endtask

    task automatic sweep7(input bit m5, input logic [6:0] m, input logic [7:0] own,
                          output int hits);
        logic a1, a2, a3;
        hits = 0;
        cfg_ten_bit = 1'b0; cfg_mask5 = m5; addr_mask = m; own_lo = own;
        for (int a = 0; a < 128; a++) begin
            logic [7:0] b, prev;
            int ic;
            bit e;
            b = {a[6:0], 1'b0};
            prev = addr_buf; ic = irq_cnt;
            e = exp7(b, own, m, m5);
            do_start();
            send_byte(b, a1, a2, a3);
            do_stop();
            if (a1) hits++;
            if (m5) check(a1 == e, "R3 ack", int'(a1), int'(e));
            else    check(a1 == e, "R2 ack", int'(a1), int'(e));
            check((irq_cnt - ic) == int'(e), "R7 irq count", irq_cnt - ic, int'(e));
            if (e) check(addr_buf == b, "R7 capture", addr_buf, b);
            else   check(addr_buf == prev, "R8 buffer kept", addr_buf, prev);
        end
    endtask

    task automatic sweep10(input bit m5, input logic [6:0] m, input logic [7:0] own,
                           output int hits);
        logic a1, a2, a3;
        hits = 0;
        cfg_ten_bit = 1'b1; cfg_mask5 = m5; addr_mask = m; own_lo = own;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b, prev;
            int ic;
            bit e;
            b = a[7:0];
            prev = addr_buf; ic = irq_cnt;
            e = exp10(b, own, m, m5);
            do_start();
            send_byte({5'b11110, own_hi, 1'b0}, a1, a2, a3);
            check(a1 == 1'b1, "R4 header ack", int'(a1), 1);
            send_byte(b, a1, a2, a3);
            do_stop();
            if (a1) hits++;
            check(a1 == e, "R5 low byte ack", int'(a1), int'(e));
            check((irq_cnt - ic) == int'(e), "R7 irq count", irq_cnt - ic, int'(e));
            if (e) check(addr_buf == b, "R7 capture", addr_buf, b);
            else   check(addr_buf == prev, "R8 buffer kept", addr_buf, prev);
        end
    endtask

    initial begin
        logic a1, a2, a3;
        int hits, ic;
        logic [7:0] prev;

        repeat (4) @(negedge clk);
        // R1 reset state
        check(ack_drive == 1'b0, "R1 ack", int'(ack_drive), 0);
        check(addr_irq == 1'b0, "R1 irq", int'(addr_irq), 0);
        check(addr_buf == 8'h00, "R1 buffer", addr_buf, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ack_drive == 1'b0 && addr_irq == 1'b0, "R1 after release",
              int'({ack_drive, addr_irq}), 0);

        // R3 / R11: narrow scheme, own A0h, mask 00111
        sweep7(1'b1, 7'b0000111, 8'hA0, hits);
        check(hits == 8, "R11 7-bit alias count", hits, 8);
        // R3: upper mask bits have no effect in narrow scheme
        sweep7(1'b1, 7'b1100010, 8'hC6, hits);
        check(hits == 2, "R3 alias count", hits, 2);
        // R2: wide scheme masks bits 7 and 1
        sweep7(1'b0, 7'b1000001, 8'h5A, hits);
        check(hits == 4, "R2 alias count", hits, 4);

        // R6: acknowledge window on a matching byte
        cfg_ten_bit = 1'b0; cfg_mask5 = 1'b0; addr_mask = 7'h00; own_lo = 8'h3C;
        do_start();
        send_byte(8'h3C, a1, a2, a3);
        check(a1 == 1'b1, "R6 ack after eighth fall", int'(a1), 1);
        check(a2 == 1'b1, "R6 ack held on ninth rise", int'(a2), 1);
        check(a3 == 1'b0, "R6 ack released after ninth fall", int'(a3), 0);
        // R10: next byte in the same transfer ignored
        ic = irq_cnt;
        send_byte(8'h3C, a1, a2, a3);
        check(a1 == 1'b0, "R10 data byte not acked", int'(a1), 0);
        check(irq_cnt == ic, "R10 no irq", irq_cnt - ic, 0);
        do_stop();

        // R2: read/write bit ignored in 7-bit addressing
        do_start();
        send_byte(8'h3D, a1, a2, a3);
        check(a1 == 1'b1, "R2 read bit ignored", int'(a1), 1);
        do_stop();

        // R8: miss then matching byte in same transfer
        prev = addr_buf; ic = irq_cnt;
        do_start();
        send_byte(8'h40, a1, a2, a3);
        check(a1 == 1'b0, "R8 miss no ack", int'(a1), 0);
        send_byte(8'h3C, a1, a2, a3);
        check(a1 == 1'b0, "R8 ignored after miss", int'(a1), 0);
        do_stop();
        check(irq_cnt == ic, "R8 no irq", irq_cnt - ic, 0);
        check(addr_buf == prev, "R8 buffer kept", addr_buf, prev);

        // R9: start mid-byte restarts the address phase
        do_start();
        for (int i = 0; i < 4; i++) clk_bit(1'b1);
        do_start();
        send_byte(8'h3C, a1, a2, a3);
        check(a1 == 1'b1, "R9 restart mid-byte", int'(a1), 1);
        do_stop();
        // R9: stop mid-byte returns to idle
        ic = irq_cnt;
        do_start();
        for (int i = 0; i < 3; i++) clk_bit(1'b0);
        do_stop();
        send_byte(8'h3C, a1, a2, a3);
        check(a1 == 1'b0, "R9 idle after stop", int'(a1), 0);
        check(irq_cnt == ic, "R9 no irq in idle", irq_cnt - ic, 0);

        // R4: full header sweep in 10-bit mode
        cfg_ten_bit = 1'b1; cfg_mask5 = 1'b1; addr_mask = 7'h7F; own_hi = 2'b10;
        for (int h = 0; h < 256; h++) begin
            logic [7:0] hb;
            bit e;
            hb = h[7:0];
            e = (hb[7:3] == 5'b11110) && (hb[2:1] == own_hi) && !hb[0];
            prev = addr_buf; ic = irq_cnt;
            do_start();
            send_byte(hb, a1, a2, a3);
            do_stop();
            check(a1 == e, "R4 header match", int'(a1), int'(e));
            check(irq_cnt == ic && addr_buf == prev, "R4 header no irq",
                  irq_cnt - ic, 0);
        end

        // R5 / R11: 10-bit second byte
        own_hi = 2'b01;
        sweep10(1'b1, 7'b0000111, 8'hA0, hits);
        check(hits == 16, "R11 10-bit alias count", hits, 16);
        sweep10(1'b0, 7'b1000001, 8'h36, hits);
        check(hits == 8, "R5 wide alias count", hits, 8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule